// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block is the control core of a microcoded processor. It keeps a control address register that points into an on-chip read-only control store of 64 microwords. Every clock the next microaddress is chosen, the word at that address is read, and both the address and the word are registered together. The registered word drives a wide control vector, one bit per control line, and also says how the following address is picked.

Each microword carries a 16-bit control field, a 2-bit flag selector, a 2-bit sequencing mode and a 6-bit target address. The modes are: step to the next address, jump to the target when the selected ALU flag is set, jump to the target always, or dispatch to the routine of the current opcode. The built-in microprogram contains a three-word fetch routine at address 0 and one four-word routine per opcode.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0 and `ctrl` shows the control field of word 0. Asserting `rst_n` takes effect at once, without waiting for a clock edge.
- R2: When the current word has mode 0 (step), the next `uaddr` is the current `uaddr` plus one, modulo 64.
- R3: When the current word has mode 1 (conditional), and `flags[sel]` is 1 for the word's selector `sel`, the next `uaddr` is the word's target field.
- R4: When the current word has mode 1 and the selected flag is 0, the next `uaddr` is the current one plus one. The other flag bits have no effect.
- R5: When the current word has mode 2 (jump), the next `uaddr` is the target field, whatever `flags` holds.
- R6: When the current word has mode 3 (dispatch), the next `uaddr` is `{opcode, 2'b00}`. `opcode` is sampled only in that cycle and changes to it at any other time have no effect.
- R7: `ctrl` always equals the control field of the word at the current `uaddr`, and it changes in the same cycle as `uaddr`. For address a, that field is `{a[5:0], ~a[5:0], a[3:0]}`.
- R8: The stored program is as follows. Words 0 and 1 step. Word 2 dispatches. Word 3 jumps to 0. For k from 1 to 15, word 4k steps, and word 4k+1 is conditional on flag index k mod 4 with target 4k+3. Words 4k+2 and 4k+3 jump to 0. Opcode 0 therefore returns to fetch.
- R9: Reset release is synchronised to the clock. After `rst_n` rises, `uaddr` stays 0 through two rising edges and becomes 1 on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| opcode | input | 4 | Opcode of the machine instruction being executed |
| flags | input | 4 | ALU condition flags; the microword picks one by index |
| ctrl | output | 16 | Horizontal control vector of the current microword |
| uaddr | output | 6 | Current control address |

## Verification
The two functions that meet in one cycle are the flag test of a conditional word and the opcode dispatch input. Both are combinational inputs to the same next-address choice, so a fault could let one leak into the other. The bench drives the opposite flag pattern during every non-conditional word and changes `opcode` right after dispatch. It applies the deciding flag pattern only in the cycle that holds the conditional word. Each walk through a routine is judged by the exact sequence of `uaddr` and `ctrl` values. Each routine is run with its selected flag both set and clear, and the other flag bits are set opposite to it.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int CTRL_W = 16;
  localparam int ADDR_W = 6;
  localparam int OPC_W  = 4;
  localparam int FLAG_W = 4;
  localparam int SEL_W  = $clog2(FLAG_W);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SLOT_W = ADDR_W - OPC_W;

  typedef enum logic [1:0] {
    NX_STEP = 2'd0,
    NX_COND = 2'd1,
    NX_JUMP = 2'd2,
    NX_DISP = 2'd3
  } nxmode_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [SEL_W-1:0]  sel;
    nxmode_e           mode;
    logic [ADDR_W-1:0] target;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  // Computes the fixed microprogram word stored at address a.
  function automatic uword_t rom_word(input int a);
    uword_t            w;
    logic [ADDR_W-1:0] av;
    logic [OPC_W-1:0]  k;
    logic [SLOT_W-1:0] slot;
    av       = ADDR_W'(a);
    k        = av[ADDR_W-1:SLOT_W];
    slot     = av[SLOT_W-1:0];
    w.ctrl   = {av, ~av, av[3:0]};
    w.sel    = '0;
    w.target = '0;
    w.mode   = NX_JUMP;
    if (k == '0) begin
      case (slot)
        2'd0, 2'd1: w.mode = NX_STEP;
        2'd2:       w.mode = NX_DISP;
        default:    w.mode = NX_JUMP;
      endcase
    end else begin
      case (slot)
        2'd0: w.mode = NX_STEP;
        2'd1: begin
          w.mode   = NX_COND;
          w.sel    = k[SEL_W-1:0];
          w.target = {k, 2'b11};
        end
        default: w.mode = NX_JUMP;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_rstsync.sv
`timescale 1ns/1ps
module useq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  uword_t table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign table_w[i] = rom_word(i);
  end

  assign word = table_w[addr];
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_addr,
  input  nxmode_e           mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] target,
  input  logic [FLAG_W-1:0] flags,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] map_addr;
  logic              cond_hit;

  always_comb begin
    seq_addr = cur_addr + ADDR_W'(1);
    map_addr = {opcode, {SLOT_W{1'b0}}};
    cond_hit = flags[sel];
    case (mode)
      NX_COND: nxt_addr = cond_hit ? target : seq_addr;
      NX_JUMP: nxt_addr = target;
      NX_DISP: nxt_addr = map_addr;
      default: nxt_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
`timescale 1ns/1ps
module useq_core
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FLAG_W-1:0] flags,
  output logic [CTRL_W-1:0] ctrl,
  output logic [ADDR_W-1:0] uaddr
);
  localparam uword_t BOOT_WORD = rom_word(0);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] car_q, car_d;
  uword_t            cbr_q, cbr_d;
  uword_t            rom_q;
  logic [ADDR_W-1:0] nxt_addr;

  useq_rstsync #(.STAGES(2)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  useq_next u_next (
    .cur_addr (car_q),
    .mode     (cbr_q.mode),
    .sel      (cbr_q.sel),
    .target   (cbr_q.target),
    .flags    (flags),
    .opcode   (opcode),
    .nxt_addr (nxt_addr)
  );

  useq_rom u_rom (
    .addr (nxt_addr),
    .word (rom_q)
  );

  always_comb begin
    car_d = nxt_addr;
    cbr_d = rom_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      car_q <= '0;
      cbr_q <= BOOT_WORD;
    end else begin
      car_q <= car_d;
      cbr_q <= cbr_d;
    end
  end

  assign ctrl  = cbr_q.ctrl;
  assign uaddr = car_q;
endmodule

// File: rtl/useq_core_sva.sv
`timescale 1ns/1ps
module useq_core_sva
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [OPC_W-1:0]  opcode,
  input logic [FLAG_W-1:0] flags,
  input logic [CTRL_W-1:0] ctrl,
  input logic [ADDR_W-1:0] uaddr,
  input nxmode_e           mode,
  input logic [SEL_W-1:0]  sel,
  input logic [ADDR_W-1:0] target
);
  a_r1_reset_addr: assert property (@(posedge clk) !rst_n |-> uaddr == '0);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == NX_STEP |=> uaddr == ADDR_W'($past(uaddr) + ADDR_W'(1)));

  a_r3_taken: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == NX_COND && flags[sel]) |=> uaddr == $past(target));

  a_r4_fallthru: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == NX_COND && !flags[sel]) |=> uaddr == ADDR_W'($past(uaddr) + ADDR_W'(1)));

  a_r5_jump: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == NX_JUMP |=> uaddr == $past(target));

  a_r6_dispatch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == NX_DISP |=> uaddr == {$past(opcode), {SLOT_W{1'b0}}});

  a_r7_ctrl_match: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl == rom_word(int'(uaddr)).ctrl);
endmodule

bind useq_core useq_core_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .opcode     (opcode),
  .flags      (flags),
  .ctrl       (ctrl),
  .uaddr      (uaddr),
  .mode       (cbr_q.mode),
  .sel        (cbr_q.sel),
  .target     (cbr_q.target)
);

// File: tb/useq_core_bench.sv
`timescale 1ns/1ps
module useq_core_bench;
  logic       clk;
  logic       rst_n;
  logic [3:0] opcode;
  logic [3:0] flags;
  logic [15:0] ctrl;
  logic [5:0]  uaddr;

  int checks;
  int failures;
  bit done;

  useq_core u_useq_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .flags  (flags),
    .ctrl   (ctrl),
    .uaddr  (uaddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_ctrl(input logic [5:0] a);
    return {a, ~a, a[3:0]};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [5:0] ea);
    checks++;
    if (uaddr !== ea || ctrl !== exp_ctrl(ea)) begin
      failures++;
      $display("FAIL %s uaddr=%0d ctrl=%h expected uaddr=%0d ctrl=%h",
               tag, uaddr, ctrl, ea, exp_ctrl(ea));
    end
  endtask

  // R1, R9: reset value, immediate assertion, synchronised release
  task automatic t_reset_release();
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", 6'd0);
    step();
    chk("R1 held in reset", 6'd0);
    rst_n = 1'b1;
    step();
    chk("R9 first edge after release", 6'd0);
    step();
    chk("R9 second edge after release", 6'd0);
    step();
    chk("R9 third edge advances R2", 6'd1);
    step();
    chk("R2 step to 2", 6'd2);
    // opcode is 0 here: R6 dispatch back to fetch
    step();
    chk("R6 opcode 0 returns to fetch", 6'd0);
  endtask

  // R2..R8: one full instruction, starting while uaddr == 0
  task automatic run_instr(input logic [3:0] op, input bit taken);
    logic [3:0] pick;
    logic [3:0] cflags;
    logic [5:0] base;
    pick   = 4'b0001 << op[1:0];
    cflags = taken ? pick : ~pick;
    base   = {op, 2'b00};
    opcode = op;
    flags  = ~cflags;
    step();
    chk("R2 fetch word 1", 6'd1);
    step();
    chk("R2 fetch word 2", 6'd2);
    step();
    if (op == 4'd0) begin
      chk("R6 R8 opcode 0 refetch", 6'd0);
      return;
    end
    chk("R6 dispatch to opcode routine", base);
    opcode = ~op;
    step();
    chk("R2 R6 routine step, opcode change ignored", base + 6'd1);
    flags = cflags;
    step();
    if (taken) chk("R3 R8 conditional taken", base + 6'd3);
    else       chk("R4 R8 conditional fall-through", base + 6'd2);
    flags = ~cflags;
    step();
    chk("R5 R7 jump back to fetch", 6'd0);
    opcode = op;
  endtask

  // R1: reset asserted in the middle of a routine
  task automatic t_mid_reset();
    opcode = 4'd9;
    flags  = 4'h0;
    step(); step(); step();
    chk("R6 dispatch before mid reset", 6'd36);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid routine", 6'd0);
    step();
    rst_n = 1'b1;
    step(); step();
    chk("R9 still held after two edges", 6'd0);
    step();
    chk("R9 resumes after mid reset", 6'd1);
    step();
    chk("R2 fetch after mid reset", 6'd2);
    opcode = 4'd0;
    step();
    chk("R6 refetch", 6'd0);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    opcode   = 4'd0;
    flags    = 4'h0;
    rst_n    = 1'b0;
    step();
    t_reset_release();
    run_instr(4'd1, 1'b1);
    run_instr(4'd1, 1'b0);
    run_instr(4'd6, 1'b1);
    run_instr(4'd7, 1'b0);
    run_instr(4'd0, 1'b0);
    run_instr(4'd15, 1'b1);
    run_instr(4'd12, 1'b0);
    run_instr(4'd8, 1'b1);
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule